// File: doc/BRIEF.md
# Charge-Control Capacitance Measurement Sequencer

This block runs a three-step charge measurement of a capacitive sensor and turns the measured times into a capacitance deviation. External current sources charge a circuit node, and an external comparator reports when that node crosses a reference voltage. The block closes four switches in a fixed order, which connects first the parasitic capacitance alone, then the parasitic plus a reference capacitor, then the parasitic plus the sensor. It counts reference-clock cycles from the start of each step to the comparator's stop event. An optional discharge step through the second current source follows the sensor step, so that the charge and discharge slopes can be averaged.

The deviation is the reference capacitance times (t2 − t1)/(t1 − t0). This ratio removes the current value and the reference voltage. It is produced in fixed point with FRAC_W fraction bits by an iterative restoring divider. The results sit on plain held outputs and are marked by a single-cycle done pulse. They are not a stream: the block applies no back-pressure and expects none, and the consumer samples them on done. The start, error and switch pins are plain level or pulse controls. The settle count, timeout limit, discharge enable and reference value must stay stable while busy is high.

Top module: `capm_seq`

## Requirements
- R1: After reset, sw_en_o is 0 and busy_o, done_o and strobe_o are low. A start_i pulse while busy_o is high is ignored.
- R2: Before every charge step, all switches are open (sw_en_o = 0) for exactly settle_cycles_i+1 cycles, counted from the cycle after start_i is sampled or the cycle after the previous stop.
- R3: Step 1 drives sw_en_o = 4'b0001 (bit 0 = SW1, bit 1 = SW2, bit 2 = SW3, bit 3 = SW4).
- R4: Step 2 drives sw_en_o = 4'b1001 (SW1 and SW4, reference capacitor added).
- R5: Step 3 drives sw_en_o = 4'b0101 (SW1 and SW3). SW3 and SW4 are never closed together.
- R6: strobe_o is high only in the first cycle of a step (index 0). The step's time is the index of the first cycle in which cmp_stop_i is sampled high, and it appears on t0_o, t1_o, t2_o or tdis_o.
- R7: With discharge_en_i high, the cycle after the step 3 stop starts a discharge step with sw_en_o = 4'b0110 and no settle cycles, and its time goes to tdis_o. tdis_o is cleared at start.
- R8: Without discharge, dev_o = sign(N)·floor(|N|·cref_i·2^FRAC_W / D) with N = t2−t1 and D = t1−t0, as a two's-complement value that truncates toward zero.
- R9: With discharge, the same formula uses N = t2+tdis−2·t1 and D = 2·(t1−t0).
- R10: When t1 ≤ t0, done_o pulses with err_div0_o = 1 and dev_o = 0.
- R11: If cmp_stop_i is not high by cycle index timeout_lim_i of a step, the block aborts. All switches open, busy_o falls, err_timeout_o rises and no done pulse follows. A stop at exactly index timeout_lim_i is accepted. Both error flags clear at the next start.
- R12: done_o is a single-cycle pulse. The time, deviation and error outputs stay unchanged from done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| discharge_en_i | input | 1 | Append the discharge step |
| settle_cycles_i | input | CNT_W | Node-reset idle count between steps |
| timeout_lim_i | input | CNT_W | Last accepted stop index in a step |
| cref_i | input | CREF_W | Reference capacitance value |
| cmp_stop_i | input | 1 | Comparator stop event |
| sw_en_o | output | 4 | Switch enables, bit 0 = SW1 … bit 3 = SW4 |
| strobe_o | output | 1 | Start event of a step |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Results valid pulse |
| t0_o | output | CNT_W | Parasitic-only interval |
| t1_o | output | CNT_W | Parasitic plus reference interval |
| t2_o | output | CNT_W | Parasitic plus sensor interval |
| tdis_o | output | CNT_W | Discharge interval |
| dev_o | output | CNT_W+CREF_W+FRAC_W+2 | Signed fixed-point deviation |
| err_timeout_o | output | 1 | Step aborted by timeout |
| err_div0_o | output | 1 | t1 not greater than t0 |

## Verification
The hardest situations to reach are the edges of a step in time. The first is a stop that lands exactly on the timeout index, next to one that never arrives. The second is the discharge step, which begins in the very cycle after the sensor stop with no settle gap between them. The stimulus tracks the step index at each falling edge and raises the comparator input at a chosen index, including index 0 and the limit itself. It also injects a start pulse in the middle of a measurement and builds t1 ≤ t0 cases that force the zero-divisor path, alongside seeded random interval sets.

// File: rtl/capm_pkg.sv
package capm_pkg;
  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_CHG, S_CALC, S_WAIT} cst_t;

  function automatic logic [3:0] sw_for_step(input logic [1:0] step);
    case (step)
      2'd0:    sw_for_step = 4'b0001;
      2'd1:    sw_for_step = 4'b1001;
      2'd2:    sw_for_step = 4'b0101;
      default: sw_for_step = 4'b0110;
    endcase
  endfunction
endpackage

// File: rtl/capm_timer.sv
module capm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + W'(1);
  end
  assign hit = (cnt == lim);
endmodule

// File: rtl/capm_div.sv
module capm_div #(
  parameter int NW = 41,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dvd,
  input  logic [DW-1:0] dvs,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);
  localparam int PW = NW + DW + 1;

  logic [NW-1:0] q, n_r;
  logic [DW-1:0] d_r;
  logic [DW:0]   rem, rem_sh;
  logic [CW-1:0] cnt;
  logic          busy;

  assign rem_sh = {rem[DW-1:0], q[NW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; n_r <= '0; d_r <= '0; rem <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        q <= dvd; n_r <= dvd; d_r <= dvs; rem <= '0;
        cnt <= CW'(NW); busy <= 1'b1;
      end else if (busy) begin
        if (rem_sh >= {1'b0, d_r}) begin
          rem <= rem_sh - {1'b0, d_r};
          q   <= {q[NW-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          q   <= {q[NW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
  assign quot = q;

  logic [PW-1:0] prod, lo_bound;
  assign prod     = PW'(q) * PW'(d_r);
  assign lo_bound = PW'(n_r);

  assert_quot_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && d_r != '0) |-> (prod <= lo_bound && lo_bound < prod + PW'(d_r)));
  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !$past(go));
endmodule

// File: rtl/capm_ctrl.sv
module capm_ctrl
  import capm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CREF_W = 16,
  parameter int FRAC_W = 8,
  parameter int NW     = CNT_W + 1 + CREF_W + FRAC_W,
  parameter int DW     = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dis_en_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic [CNT_W-1:0]  tlim_i,
  input  logic [CREF_W-1:0] cref_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  tcnt_i,
  input  logic              thit_i,
  output logic              tclr_o,
  output logic              ten_o,
  output logic [CNT_W-1:0]  tlim_o,
  output logic              div_go_o,
  output logic [NW-1:0]     div_dvd_o,
  output logic [DW-1:0]     div_dvs_o,
  input  logic              div_done_i,
  input  logic [NW-1:0]     div_q_i,
  output logic [3:0]        sw_en_o,
  output logic              strobe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  t0_o,
  output logic [CNT_W-1:0]  t1_o,
  output logic [CNT_W-1:0]  t2_o,
  output logic [CNT_W-1:0]  tdis_o,
  output logic [NW:0]       dev_o,
  output logic              err_timeout_o,
  output logic              err_div0_o
);
  localparam int NUMW = CNT_W + 2;

  cst_t           st;
  logic [1:0]     step;
  logic           neg_q;
  logic           div0;
  logic [CNT_W-1:0] dt;
  logic [NUMW-1:0]  num, magu;

  assign div0 = (t1_o <= t0_o);
  assign dt   = t1_o - t0_o;

  always_comb begin
    if (dis_en_i)
      num = {2'b00, t2_o} + {2'b00, tdis_o} - {1'b0, t1_o, 1'b0};
    else
      num = {2'b00, t2_o} - {2'b00, t1_o};
    magu = num[NUMW-1] ? (~num + NUMW'(1)) : num;
  end

  assign div_dvd_o = (NW'(magu[CNT_W:0]) * NW'(cref_i)) << FRAC_W;
  assign div_dvs_o = dis_en_i ? {1'b0, dt, 1'b0} : {2'b00, dt};
  assign div_go_o  = (st == S_CALC) && !div0;

  assign tclr_o = (st == S_IDLE) || (st == S_SETTLE && thit_i) || (st == S_CHG && stop_i);
  assign ten_o  = (st == S_SETTLE || st == S_CHG) && !tclr_o;
  assign tlim_o = (st == S_CHG) ? tlim_i : settle_i;

  assign sw_en_o  = (st == S_CHG) ? sw_for_step(step) : 4'b0000;
  assign strobe_o = (st == S_CHG) && (tcnt_i == '0);
  assign busy_o   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; neg_q <= 1'b0; done_o <= 1'b0;
      t0_o <= '0; t1_o <= '0; t2_o <= '0; tdis_o <= '0; dev_o <= '0;
      err_timeout_o <= 1'b0; err_div0_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          err_timeout_o <= 1'b0; err_div0_o <= 1'b0; tdis_o <= '0;
          step <= 2'd0; st <= S_SETTLE;
        end
        S_SETTLE: if (thit_i) st <= S_CHG;
        S_CHG: begin
          if (stop_i) begin
            case (step)
              2'd0:    t0_o   <= tcnt_i;
              2'd1:    t1_o   <= tcnt_i;
              2'd2:    t2_o   <= tcnt_i;
              default: tdis_o <= tcnt_i;
            endcase
            if (step == 2'd2 && dis_en_i) step <= 2'd3;
            else if (step >= 2'd2)        st <= S_CALC;
            else begin
              step <= step + 2'd1;
              st   <= S_SETTLE;
            end
          end else if (thit_i) begin
            err_timeout_o <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_CALC: begin
          if (div0) begin
            err_div0_o <= 1'b1; dev_o <= '0; done_o <= 1'b1; st <= S_IDLE;
          end else begin
            neg_q <= num[NUMW-1];
            st <= S_WAIT;
          end
        end
        S_WAIT: if (div_done_i) begin
          dev_o  <= neg_q ? ((NW+1)'(0) - {1'b0, div_q_i}) : {1'b0, div_q_i};
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_open_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sw_en_o == 4'b0000);
  assert_no_ref_and_sensor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en_o[2] && sw_en_o[3]));
  assert_strobe_with_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> sw_en_o != 4'b0000);
  assert_step_within_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHG) |-> tcnt_i <= tlim_i);
  assert_div0_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_div0_o) |-> done_o);
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/capm_seq.sv
module capm_seq #(
  parameter int CNT_W  = 16,
  parameter int CREF_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic                                   discharge_en_i,
  input  logic [CNT_W-1:0]                       settle_cycles_i,
  input  logic [CNT_W-1:0]                       timeout_lim_i,
  input  logic [CREF_W-1:0]                      cref_i,
  input  logic                                   cmp_stop_i,
  output logic [3:0]                             sw_en_o,
  output logic                                   strobe_o,
  output logic                                   busy_o,
  output logic                                   done_o,
  output logic [CNT_W-1:0]                       t0_o,
  output logic [CNT_W-1:0]                       t1_o,
  output logic [CNT_W-1:0]                       t2_o,
  output logic [CNT_W-1:0]                       tdis_o,
  output logic signed [CNT_W+CREF_W+FRAC_W+1:0] dev_o,
  output logic                                   err_timeout_o,
  output logic                                   err_div0_o
);
  localparam int NW = CNT_W + 1 + CREF_W + FRAC_W;
  localparam int DW = CNT_W + 2;

  logic             tclr, ten, thit, div_go, div_done;
  logic [CNT_W-1:0] tcnt, tlim;
  logic [NW-1:0]    dvd, quot;
  logic [DW-1:0]    dvs;
  logic [NW:0]      dev_u;

  capm_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tclr), .en(ten), .lim(tlim), .cnt(tcnt), .hit(thit)
  );

  capm_div #(.NW(NW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dvd(dvd), .dvs(dvs), .done(div_done), .quot(quot)
  );

  capm_ctrl #(.CNT_W(CNT_W), .CREF_W(CREF_W), .FRAC_W(FRAC_W), .NW(NW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dis_en_i(discharge_en_i),
    .settle_i(settle_cycles_i), .tlim_i(timeout_lim_i), .cref_i(cref_i), .stop_i(cmp_stop_i),
    .tcnt_i(tcnt), .thit_i(thit), .tclr_o(tclr), .ten_o(ten), .tlim_o(tlim),
    .div_go_o(div_go), .div_dvd_o(dvd), .div_dvs_o(dvs), .div_done_i(div_done), .div_q_i(quot),
    .sw_en_o(sw_en_o), .strobe_o(strobe_o), .busy_o(busy_o), .done_o(done_o),
    .t0_o(t0_o), .t1_o(t1_o), .t2_o(t2_o), .tdis_o(tdis_o), .dev_o(dev_u),
    .err_timeout_o(err_timeout_o), .err_div0_o(err_div0_o)
  );

  assign dev_o = $signed(dev_u);
endmodule

// File: tb/sim_capm_seq.sv
module sim_capm_seq;
  localparam int CNT_W = 16, CREF_W = 16, FRAC_W = 8;
  localparam int DEVW = CNT_W + CREF_W + FRAC_W + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dis = 1'b0, cmp_stop = 1'b0;
  logic [CNT_W-1:0] settle = '0, tlim = '0;
  logic [CREF_W-1:0] cref = '0;
  logic [3:0] sw_en;
  logic strobe, busy, done, err_to, err_d0;
  logic [CNT_W-1:0] t0, t1, t2, tdis;
  logic signed [DEVW-1:0] dev;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  capm_seq #(.CNT_W(CNT_W), .CREF_W(CREF_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .discharge_en_i(dis),
    .settle_cycles_i(settle), .timeout_lim_i(tlim), .cref_i(cref), .cmp_stop_i(cmp_stop),
    .sw_en_o(sw_en), .strobe_o(strobe), .busy_o(busy), .done_o(done),
    .t0_o(t0), .t1_o(t1), .t2_o(t2), .tdis_o(tdis), .dev_o(dev),
    .err_timeout_o(err_to), .err_div0_o(err_d0)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_dev(int a0, int a1, int a2, int ad, bit dsc, longint cr);
    longint n, d, mag, q;
    n = dsc ? (a2 + ad - 2 * a1) : (a2 - a1);
    d = dsc ? 2 * (a1 - a0) : (a1 - a0);
    if (d <= 0) return 0;
    mag = ((n < 0 ? -n : n) * cr) << FRAC_W;
    q = mag / d;
    return (n < 0) ? -q : q;
  endfunction

  // Called at a falling edge; returns at the falling edge after the stop.
  task automatic drive_step(input int d, input logic [3:0] esw, input int esettle,
                            input string tag);
    int n = 0, bad = 0, sbad = 0;
    while (strobe !== 1'b1 && n < 2000) begin
      if (sw_en !== 4'b0000) bad++;
      @(negedge clk); cmp_stop = 1'b0; n++;
    end
    chk({tag, " R2 settle length"}, n, esettle);
    chk({tag, " R2 switches open while settling"}, bad, 0);
    chk({tag, " switch pattern"}, sw_en, esw);
    cmp_stop = (d == 0);
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      if (strobe !== 1'b0) sbad++;
      cmp_stop = (i == d);
    end
    chk({tag, " R6 strobe only at index 0"}, sbad, 0);
    @(negedge clk); cmp_stop = 1'b0;
  endtask

  task automatic measure(input int d0, input int d1, input int d2, input int dd, input bit dsc,
                         input int sc, input int lim, input int cr, input bit spurious);
    int k = 0;
    longint ed;
    dis = dsc; settle = CNT_W'(sc); tlim = CNT_W'(lim); cref = CREF_W'(cr);
    start = 1'b1; @(negedge clk); start = 1'b0;
    drive_step(d0, 4'b0001, sc + 1, "R3 step1");
    if (spurious) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      drive_step(d1, 4'b1001, sc, "R4 step2 R1 spurious start");
    end else drive_step(d1, 4'b1001, sc + 1, "R4 step2");
    drive_step(d2, 4'b0101, sc + 1, "R5 step3");
    if (dsc) drive_step(dd, 4'b0110, 0, "R7 discharge");
    while (done !== 1'b1 && k < 500) begin @(negedge clk); k++; end
    chk("R12 done seen", done, 1);
    chk("R6 t0", t0, d0);
    chk("R6 t1", t1, d1);
    chk("R6 t2", t2, d2);
    chk("R7 tdis", tdis, dsc ? dd : 0);
    ed = exp_dev(d0, d1, d2, dd, dsc, cr);
    chk(dsc ? "R9 deviation" : "R8 deviation", longint'(dev), ed);
    chk("R10 div0 flag", err_d0, (d1 <= d0) ? 1 : 0);
    chk("R11 timeout flag clear", err_to, 0);
    @(negedge clk);
    chk("R12 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R12 deviation held", longint'(dev), ed);
    chk("R12 t2 held", t2, d2);
    chk("R1 idle switches open", sw_en, 0);
  endtask

  task automatic timeout_case(input int d0, input int sc, input int lim);
    int n = 0, dseen = 0;
    dis = 1'b0; settle = CNT_W'(sc); tlim = CNT_W'(lim);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (strobe !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    cmp_stop = 1'b0;
    for (int i = 1; i <= lim; i++) @(negedge clk);
    chk("R11 still busy at limit index", busy, 1);
    @(negedge clk);
    chk("R11 aborted busy low", busy, 0);
    chk("R11 switches open", sw_en, 0);
    chk("R11 error flag", err_to, 1);
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (done) dseen++; end
    chk("R11 no done after abort", dseen, 0);
    chk("R11 flag held", err_to, 1);
    if (d0 >= 0) chk("R11 t0 untouched", t0, d0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset switches", sw_en, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset strobe", strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);
    measure(5, 12, 20, 0, 1'b0, 2, 70, 1000, 1'b0);
    measure(0, 7, 3, 0, 1'b0, 0, 70, 40000, 1'b0);     // negative deviation, stop at index 0
    measure(4, 9, 15, 13, 1'b1, 1, 70, 2500, 1'b0);
    measure(6, 6, 30, 0, 1'b0, 3, 70, 5000, 1'b0);     // R10 equal times
    measure(9, 4, 30, 22, 1'b1, 1, 70, 5000, 1'b0);    // R10 t1 < t0
    measure(3, 11, 40, 0, 1'b0, 2, 40, 777, 1'b1);     // stop exactly at limit, spurious start
    measure(2, 10, 17, 0, 1'b0, 1, 60, 65535, 1'b0);
    timeout_case(2, 1, 25);
    measure(8, 20, 33, 31, 1'b1, 0, 60, 1234, 1'b0);   // R11 flags cleared by start
    for (int r = 0; r < 30; r++) begin
      int a0, a1, a2, ad, sc, lim, cr;
      bit dsc;
      a0 = $urandom_range(0, 15);
      a1 = a0 + $urandom_range(0, 25);
      a2 = $urandom_range(0, 60);
      ad = $urandom_range(0, 60);
      dsc = 1'($urandom_range(0, 1));
      sc = $urandom_range(0, 4);
      lim = $urandom_range(60, 80);
      cr = $urandom_range(0, 65535);
      measure(a0, a1, a2, ad, dsc, sc, lim, cr, (r % 7) == 3);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule